// File: doc/BRIEF.md
# Dual-Mode Noise LFSR Generator

This block is the pseudo-random source of a noise voice in an audio synthesiser. A 15-bit shift register moves one place to the right each time a down-counting period timer runs out. The bit shifted in at the top is the exclusive-OR of the lowest bit with one of two taps. One tap gives a long, hiss-like sequence. The other gives a short, buzzy, tonal one.

The timer only moves on cycles where the enable tick is high, so a shared prescaler sets the base rate. The 4-bit period selector picks one of sixteen reload lengths from a parameter table. The selector is read only when the timer reloads. The mode bit is read only when the register steps.

The output is a one-bit gate for the later volume stage, along with the raw register value.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `lfsr_q` is 15'h0001, `gate_out` is 0, and the timer count is 1. The first enabled tick after reset therefore steps the register.
- R2: On a clock edge where `tick_en` is 0, neither the register nor the timer changes. This holds whatever `period_sel` and `mode_short` are doing.
- R3: The timer counts enabled ticks, not clock cycles. After each expiry, the next step comes on the P-th enabled tick, where P is the table entry chosen by `period_sel` at that expiry.
- R4: With `mode_short` = 0, a step sets `lfsr_q[13:0]` to the old `lfsr_q[14:1]` and sets `lfsr_q[14]` to old bit 0 XOR old bit 1.
- R5: With `mode_short` = 1, a step shifts the same way but sets `lfsr_q[14]` to old bit 0 XOR old bit 6.
- R6: `gate_out` is the inverse of `lfsr_q[0]`: the voice is muted when bit 0 is 1.
- R7: `period_sel` is sampled only on the expiring tick. Changing it in the middle of a count does not shorten or lengthen that count.
- R8: `mode_short` is sampled on the stepping edge itself. A change made in the same cycle as an expiry already governs that step.
- R9: Starting from the reset value, `lfsr_q` never becomes zero in either mode.
- R10: A table entry of 0 is treated as a period of 1, so the selector can never stop the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Enable tick that advances the period timer |
| period_sel | input | 4 | Index into the period table, read on expiry |
| mode_short | input | 1 | 0 selects the long tap (bit 1), 1 selects the short tap (bit 6) |
| gate_out | output | 1 | Noise gate, 1 lets sound through |
| lfsr_q | output | 15 | Current shift register value |

## Verification
Two things can happen in the same cycle: the timer reload, which reads `period_sel`, and the register step, which reads `mode_short`. A bench model tracks the timer, detects the cycle where the count is 1, and changes both the selector and the mode exactly on that enabled tick. The model then expects the new mode to shape the current step and the new period to set the following interval. Comparing every cycle against the model shows any skew of one tick in either direction.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int LFSR_W   = 15;
  localparam int SEL_W    = 4;
  localparam int TBL_N    = 1 << SEL_W;
  localparam int TAP_LONG = 1;
  localparam int TAP_SHRT = 6;

  typedef enum logic {FB_LONG = 1'b0, FB_SHORT = 1'b1} fb_mode_e;

  // One right shift with the selected feedback tap entering at the top.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v,
                                                   input fb_mode_e m);
    logic fb;
    fb = v[0] ^ ((m == FB_SHORT) ? v[TAP_SHRT] : v[TAP_LONG]);
    return {fb, v[LFSR_W-1:1]};
  endfunction

  // A zero period would stall the timer; clamp it to one.
  function automatic logic [31:0] clamp_period(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction
endpackage

// File: rtl/noise_period_rom.sv
module noise_period_rom
  import noise_pkg::*;
#(
  parameter int PW = 12,
  parameter logic [PW-1:0] TBL [TBL_N] = '{default: '0}
) (
  input  logic [SEL_W-1:0] sel,
  output logic [PW-1:0]    period
);
  logic [PW-1:0] raw;
  always_comb begin
    raw    = TBL[sel];
    period = (raw == '0) ? PW'(1) : raw;
  end
endmodule

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] reload_val,
  output logic          expire
);
  logic [PW-1:0] cnt_q;

  assign expire = tick && (cnt_q == PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= PW'(1);
    else if (expire)  cnt_q <= reload_val;
    else if (tick)    cnt_q <= cnt_q - PW'(1);
  end
endmodule

// File: rtl/noise_shreg.sv
module noise_shreg
  import noise_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  fb_mode_e          mode,
  output logic [LFSR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= LFSR_W'(1);
    else if (step)  q <= lfsr_step(q, mode);
  end
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int PW = 12,
  parameter logic [PW-1:0] PERIOD_TBL [TBL_N] = '{
    12'd4,   12'd8,   12'd16,  12'd32,  12'd64,  12'd96,  12'd128,  12'd160,
    12'd202, 12'd254, 12'd380, 12'd508, 12'd762, 12'd1016, 12'd2034, 12'd4068}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [SEL_W-1:0]  period_sel,
  input  logic              mode_short,
  output logic              gate_out,
  output logic [LFSR_W-1:0] lfsr_q
);
  logic [PW-1:0] reload_val;
  logic          tmr_expire;
  fb_mode_e      fb_mode;

  assign fb_mode = mode_short ? FB_SHORT : FB_LONG;

  noise_period_rom #(.PW(PW), .TBL(PERIOD_TBL)) u_rom (
    .sel    (period_sel),
    .period (reload_val)
  );

  noise_timer #(.PW(PW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .reload_val (reload_val),
    .expire     (tmr_expire)
  );

  noise_shreg u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (tmr_expire),
    .mode  (fb_mode),
    .q     (lfsr_q)
  );

  assign gate_out = ~lfsr_q[0];
endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        mode_short,
  input logic        expire,
  input logic        gate_out,
  input logic [14:0] lfsr_q
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(lfsr_q));

  p_expire_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick_en);

  p_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> $stable(lfsr_q));

  p_long_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_short) |=> (lfsr_q[13:0] == $past(lfsr_q[14:1])) &&
      (lfsr_q[14] == ($past(lfsr_q[0]) ^ $past(lfsr_q[1]))));

  p_short_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_short) |=> (lfsr_q[13:0] == $past(lfsr_q[14:1])) &&
      (lfsr_q[14] == ($past(lfsr_q[0]) ^ $past(lfsr_q[6]))));

  p_gate_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lfsr_q[0]) |-> !gate_out);

  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 15'd0);
endmodule

bind noise_lfsr_gen noise_lfsr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .mode_short (mode_short),
  .expire     (tmr_expire),
  .gate_out   (gate_out),
  .lfsr_q     (lfsr_q)
);

// File: tb/noise_lfsr_gen_tb.sv
module noise_lfsr_gen_tb;
  localparam logic [11:0] TB_TBL [16] = '{
    12'd1, 12'd2, 12'd3, 12'd4, 12'd5, 12'd6, 12'd7, 12'd8,
    12'd9, 12'd10, 12'd11, 12'd12, 12'd13, 12'd14, 12'd15, 12'd0};

  // Each vector: {cycles[7:0], tick_mode[1:0] (0 off,1 every,2 alternate), mode, sel[3:0], tag[3:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {8'd6,  2'd0, 1'b0, 4'd0,  4'd2},
    {8'd20, 2'd1, 1'b0, 4'd0,  4'd4},
    {8'd30, 2'd1, 1'b0, 4'd3,  4'd3},
    {8'd25, 2'd1, 1'b1, 4'd2,  4'd5},
    {8'd40, 2'd1, 1'b1, 4'd0,  4'd5},
    {8'd12, 2'd0, 1'b1, 4'd5,  4'd2},
    {8'd30, 2'd1, 1'b0, 4'd15, 4'd10},
    {8'd33, 2'd2, 1'b0, 4'd6,  4'd3},
    {8'd28, 2'd1, 1'b0, 4'd7,  4'd7},
    {8'd20, 2'd1, 1'b1, 4'd9,  4'd8}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [3:0]  period_sel = 4'd0;
  logic        mode_short = 1'b0;
  logic        gate_out;
  logic [14:0] lfsr_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [14:0] m_lfsr;
  int          m_cnt;

  always #4 clk = ~clk;

  noise_lfsr_gen #(.PW(12), .PERIOD_TBL(TB_TBL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_sel(period_sel),
    .mode_short(mode_short), .gate_out(gate_out), .lfsr_q(lfsr_q));

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, advance model at posedge, compare at next negedge.
  task automatic cyc(input logic t, input logic [3:0] s, input logic m, input string req);
    logic fb;
    tick_en = t; period_sel = s; mode_short = m;
    @(posedge clk);
    if (t) begin
      if (m_cnt == 1) begin
        fb = m ? (m_lfsr[0] ^ m_lfsr[6]) : (m_lfsr[0] ^ m_lfsr[1]);
        m_lfsr = {fb, m_lfsr[14:1]};
        m_cnt = (TB_TBL[s] == 12'd0) ? 1 : int'(TB_TBL[s]);
      end else m_cnt = m_cnt - 1;
    end
    @(negedge clk);
    check(req, 32'(lfsr_q), 32'(m_lfsr));
    check("R6", 32'(gate_out), 32'(!m_lfsr[0]));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_lfsr = 15'd1; m_cnt = 1;
    repeat (3) @(negedge clk);
    check("R1", 32'(lfsr_q), 32'd1);
    check("R1", 32'(gate_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(lfsr_q), 32'd1);
    // R1: very first enabled tick steps
    cyc(1'b1, 4'd4, 1'b0, "R1");
    check("R1", 32'(lfsr_q), 32'h4000);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][18:11]); k++) begin
        logic t;
        t = (VEC[v][10:9] == 2'd1) || (VEC[v][10:9] == 2'd2 && k[0]);
        cyc(t, VEC[v][7:4], VEC[v][8], tag_name(int'(VEC[v][3:0])));
      end
    end

    // R7: selector wiggling mid-count changes nothing until expiry
    while (m_cnt == 1) cyc(1'b1, 4'd9, 1'b0, "R7");
    for (int k = 0; k < 30; k++)
      cyc(1'b1, (m_cnt == 1) ? 4'd4 : 4'(k), 1'b0, "R7");

    // R8 with R7: mode and selector both change exactly on the expiring tick
    for (int r = 0; r < 6; r++) begin
      while (m_cnt != 1) cyc(1'b1, 4'd2, r[0], "R8");
      cyc(1'b1, 4'(3 + r), ~r[0], "R8");
      while (m_cnt != 1) cyc(1'b1, 4'd0, r[0], "R7");
    end

    // R2: no tick, inputs toggling
    for (int k = 0; k < 8; k++) cyc(1'b0, 4'(k), k[0], "R2");

    // R9: long runs in both modes never reach zero
    for (int k = 0; k < 300; k++) begin
      cyc(1'b1, 4'd0, k >= 150, "R9");
      check("R9", 32'(lfsr_q != 15'd0), 32'd1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule